// File: doc/BRIEF.md
# Dual-Port Microcode RAM Controller

This block holds a word-organised RAM that two owners share in turn. In normal mode a host bus reaches the array and reads or writes it in byte, halfword or word units through per-byte write strobes. The same bus reaches one small control register. Once either of two microengine emulation enables is set, the host loses the array and two fetch ports, one per microengine, read instruction words from it. Both ports can fetch in the same cycle.

The control register also holds a disable bit and a stop bit. The disable bit shuts the host out of the array. The stop bit models the lowest-power state: the array keeps its contents but cannot be read or written, and only the stop bit can still be changed. A synchronous reset lets a host write that was accepted just before it finish, then refuses new writes for as long as it lasts. A freeze input exists but does not change behaviour. Software loads microcode through the host bus in normal mode and then sets the emulation enables.

Top module: `ucode_ram_ctrl`

## Requirements
- R1: In normal mode (control register all zero), a host request is answered by `host_ack` high exactly one cycle later. A write updates only the bytes whose strobe bit is set (strobe bit n covers data bits 8n+7..8n). A read returns the whole stored word.
- R2: A read issued in the cycle directly after a write to the same word returns the merged data of that write.
- R3: The control register is selected by `host_reg_sel` and reads back as stop at bit 0, disable at bit 1, engine A emulation at bit 2 and engine B emulation at bit 3, with zeros above. It is written only when strobe bit 0 is set, and all its bits are 0 after reset.
- R4: While the disable bit is 1, a host array read or write is answered with `host_err` and returns 0, and the array does not change. The register stays reachable.
- R5: While an emulation enable is set, host array accesses are answered with `host_err` and leave the array unchanged. The fetch port of an enabled engine returns the addressed word with its valid high one cycle after a request. The port of an engine that is not enabled never raises its valid.
- R6: Both fetch ports return correct words when they request different addresses in the same cycle.
- R7: While stop is 1, host array accesses are answered with `host_err`. Array contents are retained and can be read once stop is cleared.
- R8: While stop is 1, a register write changes only the stop bit. The disable bit and the emulation enables keep their values.
- R9: A register write that sets stop leaves stop at 0 if either emulation enable would be 1 after that write.
- R10: A host write acknowledged in the cycle before a synchronous reset edge still reaches the array. Requests made while reset is low get no acknowledge and do not change the array. Array contents survive reset.
- R11: The `freeze` input has no effect: accesses are acknowledged and served the same way with freeze high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | Debug freeze request, ignored |
| host_req | input | 1 | Host request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg_sel | input | 1 | 1 = control register, 0 = array |
| host_addr | input | ADDR_W | Array word address |
| host_wstrb | input | 4 | Per-byte write strobes |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | Response valid, one cycle after request |
| host_err | output | 1 | Error response (qualified by ack) |
| host_rdata | output | 32 | Read data (qualified by ack) |
| eng_a_req | input | 1 | Engine A fetch request |
| eng_a_addr | input | ADDR_W | Engine A fetch word address |
| eng_a_vld | output | 1 | Engine A fetch data valid |
| eng_a_data | output | 32 | Engine A instruction word |
| eng_b_req | input | 1 | Engine B fetch request |
| eng_b_addr | input | ADDR_W | Engine B fetch word address |
| eng_b_vld | output | 1 | Engine B fetch data valid |
| eng_b_data | output | 32 | Engine B instruction word |

## Verification
The hardest case to reach is the write that is still in flight when a synchronous reset edge arrives. The host must have received its acknowledge, and reset must fall in exactly that cycle, before the array commit. The bench reaches it with a directed sequence: it drives a write, lowers `rst_n` on the same falling edge where it samples the acknowledge, and then tries a second write while reset is held. Once reset is released, both words are read back. The back-to-back read-after-write bypass case is reached by random traffic confined to sixteen words, so that consecutive requests often hit the same word.

// File: rtl/ucr_pkg.sv
// Package: shared constants, control register type and byte-merge helper
// for the dual-port microcode RAM controller.
// Assumes a 32-bit data path split into four byte lanes.
package ucr_pkg;

    localparam int UCR_DW = 32;
    localparam int UCR_NB = UCR_DW / 8;

    // Control register layout, MSB first: eng B emu, eng A emu, disable, stop.
    typedef struct packed {
        logic [1:0] emu;
        logic       dis;
        logic       stop;
    } ucr_ctrl_t;

    localparam int UCR_CTRL_W = $bits(ucr_ctrl_t);

    // Merge the strobed bytes of a new word over an old word.
    function automatic logic [UCR_DW-1:0] ucr_merge(
        input logic [UCR_DW-1:0] old_w,
        input logic [UCR_DW-1:0] new_w,
        input logic [UCR_NB-1:0] strb
    );
        logic [UCR_DW-1:0] res;
        res = old_w;
        for (int b = 0; b < UCR_NB; b++) begin
            if (strb[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/ucr_regs.sv
// Module: ucr_regs
// Holds the control register (stop, disable, two emulation enables).
// Assumes: wr_en is a single-cycle pulse from the host interface; while stop
// is set only the stop bit can change; stop is refused whenever either
// emulation enable would be set after the write.
module ucr_regs
    import ucr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [UCR_CTRL_W-1:0] wdata,
    output ucr_ctrl_t             ctrl_o
);

    ucr_ctrl_t ctrl_q;
    ucr_ctrl_t ctrl_d;
    ucr_ctrl_t req_v;

    // Next value: stop-mode keeps everything but stop; stop needs emu clear.
    always_comb begin
        req_v  = ucr_ctrl_t'(wdata);
        ctrl_d = ctrl_q;
        if (wr_en) begin
            if (ctrl_q.stop) begin
                ctrl_d.stop = req_v.stop;
            end else begin
                ctrl_d      = req_v;
                ctrl_d.stop = req_v.stop & ~(|req_v.emu);
            end
        end
    end

    // Register update with synchronous reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    // R9
    stop_excl_emu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.stop |-> (ctrl_q.emu == 2'b00));

    // R8
    stop_freezes_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.stop |=> ($stable(ctrl_q.emu) && $stable(ctrl_q.dis)));

endmodule

// File: rtl/ucr_host_if.sv
// Module: ucr_host_if
// Decodes host requests, answers each one cycle later, and stages array
// writes in a one-entry pending register that commits on the next edge
// even if that edge carries reset.
// Assumes: at most one request per cycle; requests are ignored in reset.
module ucr_host_if
    import ucr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic                  host_reg_sel,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [UCR_NB-1:0]     host_wstrb,
    input  logic [UCR_DW-1:0]     host_wdata,
    output logic                  host_ack,
    output logic                  host_err,
    output logic [UCR_DW-1:0]     host_rdata,
    input  ucr_ctrl_t             ctrl,
    output logic                  reg_wr,
    output logic [UCR_CTRL_W-1:0] reg_wdata,
    output logic                  pw_valid,
    output logic [ADDR_W-1:0]     pw_addr,
    output logic [UCR_DW-1:0]     pw_data,
    output logic [UCR_NB-1:0]     pw_strb,
    output logic                  rd_en,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic [UCR_DW-1:0]     arr_rdata
);

    logic      arr_block;
    logic      arr_req;
    logic      ack_q, err_q, sel_reg_q, arr_rd_q;
    ucr_ctrl_t reg_snap_q;

    // Array is off-limits in stop, when disabled, or in emulation.
    assign arr_block = ctrl.stop | ctrl.dis | (|ctrl.emu);
    assign arr_req   = host_req & ~host_reg_sel;

    // Combinational requests toward the register file and the array read port.
    assign reg_wr    = rst_n & host_req & host_we & host_reg_sel & host_wstrb[0];
    assign reg_wdata = host_wdata[UCR_CTRL_W-1:0];
    assign rd_en     = rst_n & arr_req & ~host_we & ~arr_block;
    assign rd_addr   = host_addr;

    // Response and pending-write flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            err_q     <= 1'b0;
            sel_reg_q <= 1'b0;
            arr_rd_q  <= 1'b0;
            pw_valid  <= 1'b0;
        end else begin
            ack_q     <= host_req;
            err_q     <= arr_req & arr_block;
            sel_reg_q <= host_req & host_reg_sel;
            arr_rd_q  <= rd_en;
            pw_valid  <= arr_req & host_we & ~arr_block;
        end
    end

    // Payload of the pending write and register snapshot, no reset needed.
    always_ff @(posedge clk) begin
        if (host_req) begin
            pw_addr    <= host_addr;
            pw_data    <= host_wdata;
            pw_strb    <= host_wstrb;
            reg_snap_q <= ctrl;
        end
    end

    // Read data select: register snapshot, array word, or zero.
    always_comb begin
        host_rdata = '0;
        if (sel_reg_q)     host_rdata = {{(UCR_DW-UCR_CTRL_W){1'b0}}, reg_snap_q};
        else if (arr_rd_q) host_rdata = arr_rdata;
    end

    assign host_ack = ack_q;
    assign host_err = err_q;

    // R1
    req_gets_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |=> host_ack);

    // R4
    blocked_gets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && (ctrl.dis || ctrl.stop || ctrl.emu != 2'b00)) |=> (host_err && !pw_valid));

endmodule

// File: rtl/ucr_array.sv
// Module: ucr_array
// Word RAM with one strobed write port, one host read port with
// write-to-read bypass, and NPORT independent fetch read ports.
// Assumes: contents are never reset; fetch ports are enabled only in
// emulation and never in stop.
module ucr_array
    import ucr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NPORT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stop_i,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [UCR_DW-1:0]       wr_data,
    input  logic [UCR_NB-1:0]       wr_strb,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [UCR_DW-1:0]       rd_data,
    input  logic [NPORT-1:0]        fe_req,
    input  logic [NPORT-1:0]        fe_en,
    input  logic [NPORT*ADDR_W-1:0] fe_addr,
    output logic [NPORT-1:0]        fe_vld,
    output logic [NPORT*UCR_DW-1:0] fe_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [UCR_DW-1:0] mem [DEPTH];
    logic [UCR_DW-1:0] rd_q;

    // Byte-strobed write; runs regardless of reset so an accepted write lands.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= ucr_merge(mem[wr_addr], wr_data, wr_strb);
    end

    // Host read with bypass of a write committing at the same edge.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            if (wr_en && wr_addr == rd_addr) rd_q <= ucr_merge(mem[rd_addr], wr_data, wr_strb);
            else                             rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_fetch
        logic              vld_q;
        logic [UCR_DW-1:0] dat_q;
        logic              go;

        assign go = fe_req[p] & fe_en[p] & ~stop_i;

        // Fetch data register for this port.
        always_ff @(posedge clk) begin
            if (go) dat_q <= mem[fe_addr[p*ADDR_W +: ADDR_W]];
        end

        // Fetch valid flag for this port.
        always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= go;
        end

        assign fe_vld[p]                  = vld_q;
        assign fe_data[p*UCR_DW +: UCR_DW] = dat_q;

        // R5
        fetch_needs_emu_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q |-> $past(fe_en[p]));
    end

    // R7
    no_write_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !stop_i);

endmodule

// File: rtl/ucode_ram_ctrl.sv
// Module: ucode_ram_ctrl (top)
// Dual-port microcode RAM controller: host bus to array and control
// register in normal mode, two microengine fetch ports in emulation mode.
// Assumes: freeze is only observed, never acted on.
module ucode_ram_ctrl
    import ucr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_reg_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [3:0]        host_wstrb,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic              host_err,
    output logic [31:0]       host_rdata,
    input  logic              eng_a_req,
    input  logic [ADDR_W-1:0] eng_a_addr,
    output logic              eng_a_vld,
    output logic [31:0]       eng_a_data,
    input  logic              eng_b_req,
    input  logic [ADDR_W-1:0] eng_b_addr,
    output logic              eng_b_vld,
    output logic [31:0]       eng_b_data
);

    localparam int NPORT = 2;

    ucr_ctrl_t               ctrl;
    logic                    reg_wr;
    logic [UCR_CTRL_W-1:0]   reg_wdata;
    logic                    pw_valid;
    logic [ADDR_W-1:0]       pw_addr;
    logic [UCR_DW-1:0]       pw_data;
    logic [UCR_NB-1:0]       pw_strb;
    logic                    rd_en;
    logic [ADDR_W-1:0]       rd_addr;
    logic [UCR_DW-1:0]       arr_rdata;
    logic [NPORT-1:0]        fe_vld;
    logic [NPORT*UCR_DW-1:0] fe_data;

    ucr_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wdata  (reg_wdata),
        .ctrl_o (ctrl)
    );

    ucr_host_if #(.ADDR_W(ADDR_W)) u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_we      (host_we),
        .host_reg_sel (host_reg_sel),
        .host_addr    (host_addr),
        .host_wstrb   (host_wstrb),
        .host_wdata   (host_wdata),
        .host_ack     (host_ack),
        .host_err     (host_err),
        .host_rdata   (host_rdata),
        .ctrl         (ctrl),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .pw_valid     (pw_valid),
        .pw_addr      (pw_addr),
        .pw_data      (pw_data),
        .pw_strb      (pw_strb),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .arr_rdata    (arr_rdata)
    );

    ucr_array #(.ADDR_W(ADDR_W), .NPORT(NPORT)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_i  (ctrl.stop),
        .wr_en   (pw_valid),
        .wr_addr (pw_addr),
        .wr_data (pw_data),
        .wr_strb (pw_strb),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (arr_rdata),
        .fe_req  ({eng_b_req, eng_a_req}),
        .fe_en   (ctrl.emu),
        .fe_addr ({eng_b_addr, eng_a_addr}),
        .fe_vld  (fe_vld),
        .fe_data (fe_data)
    );

    assign eng_a_vld  = fe_vld[0];
    assign eng_b_vld  = fe_vld[1];
    assign eng_a_data = fe_data[0 +: UCR_DW];
    assign eng_b_data = fe_data[UCR_DW +: UCR_DW];

    // R11
    freeze_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && host_req) |=> host_ack);

endmodule

// File: tb/test_ucode_ram_ctrl.sv
`timescale 1ns/1ps
module test_ucode_ram_ctrl;

    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freeze = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0, host_reg_sel = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [3:0]    host_wstrb = '0;
    logic [31:0]   host_wdata = '0;
    logic          host_ack, host_err;
    logic [31:0]   host_rdata;
    logic          eng_a_req = 1'b0, eng_b_req = 1'b0;
    logic [AW-1:0] eng_a_addr = '0, eng_b_addr = '0;
    logic          eng_a_vld, eng_b_vld;
    logic [31:0]   eng_a_data, eng_b_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] model [DEPTH];

    always #2.5 clk = ~clk;

    ucode_ram_ctrl #(.ADDR_W(AW)) i_ucode_ram_ctrl (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .host_req(host_req), .host_we(host_we), .host_reg_sel(host_reg_sel),
        .host_addr(host_addr), .host_wstrb(host_wstrb), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_err(host_err), .host_rdata(host_rdata),
        .eng_a_req(eng_a_req), .eng_a_addr(eng_a_addr), .eng_a_vld(eng_a_vld), .eng_a_data(eng_a_data),
        .eng_b_req(eng_b_req), .eng_b_addr(eng_b_addr), .eng_b_vld(eng_b_vld), .eng_b_data(eng_b_data)
    );

    function automatic logic [31:0] merge_exp(logic [31:0] o, logic [31:0] n, logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at the current falling edge; sample the response one cycle later.
    task automatic host(input bit rs, input bit we, input logic [AW-1:0] a,
                        input logic [3:0] s, input logic [31:0] d,
                        output logic ack, output logic err, output logic [31:0] rd);
        host_req = 1'b1; host_reg_sel = rs; host_we = we;
        host_addr = a; host_wstrb = s; host_wdata = d;
        @(negedge clk);
        ack = host_ack; err = host_err; rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        logic a, e; logic [31:0] r;
        host(1'b1, 1'b1, '0, 4'h1, {28'h0, v}, a, e, r);
    endtask

    task automatic rd_ctrl(input string req, input logic [31:0] exp);
        logic a, e; logic [31:0] r;
        host(1'b1, 1'b0, '0, 4'h0, 32'h0, a, e, r);
        check(req, r, exp);
    endtask

    task automatic rd_arr(input string req, input logic [AW-1:0] ad, input logic [31:0] exp);
        logic a, e; logic [31:0] r;
        host(1'b0, 1'b0, ad, 4'h0, 32'h0, a, e, r);
        check(req, {e, r[30:0]} ^ {1'b0, 31'h0}, {1'b0, exp[30:0]});
        check(req, r, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic a, e; logic [31:0] r;
        logic [AW-1:0] ad; logic [3:0] s; logic [31:0] d;
        void'($urandom(32'h1c0de5));
        repeat (3) @(negedge clk);
        check("R10 ack low in reset", {31'h0, host_ack}, 32'h0);
        rst_n = 1'b1;
        // R3 reset value
        rd_ctrl("R3 reset value", 32'h0);

        // R1 fill the whole array with full-word writes
        for (int i = 0; i < DEPTH; i++) begin
            d = $urandom();
            host(1'b0, 1'b1, i[AW-1:0], 4'hF, d, a, e, r);
            model[i] = d;
            if (i == 0) check("R1 write ack", {30'h0, a, e}, 32'h2);
        end

        // R1 R2 R11 random traffic over 16 words, back-to-back, random freeze
        for (int i = 0; i < 400; i++) begin
            ad = AW'($urandom_range(0, 15));
            s  = 4'($urandom_range(1, 15));
            d  = $urandom();
            freeze = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 1) begin
                host(1'b0, 1'b1, ad, s, d, a, e, r);
                model[ad] = merge_exp(model[ad], d, s);
                check(freeze ? "R11 ack under freeze" : "R1 write ack", {30'h0, a, e}, 32'h2);
            end else begin
                host(1'b0, 1'b0, ad, 4'h0, 32'h0, a, e, r);
                check(freeze ? "R11 read under freeze" : "R2 read data", r, model[ad]);
            end
        end
        freeze = 1'b0;

        // R2 directed write then immediate read of the same word
        host(1'b0, 1'b1, 8'd3, 4'b0101, 32'hAABBCCDD, a, e, r);
        model[3] = merge_exp(model[3], 32'hAABBCCDD, 4'b0101);
        rd_arr("R2 bypass", 8'd3, model[3]);

        // R3 strobe bit 0 required for a register write
        host(1'b1, 1'b1, '0, 4'h2, 32'h2, a, e, r);
        rd_ctrl("R3 strobe gate", 32'h0);

        // R4 disable bit
        wr_ctrl(4'h2);
        rd_ctrl("R3 disable readback", 32'h2);
        host(1'b0, 1'b1, 8'd5, 4'hF, 32'hDEADBEEF, a, e, r);
        check("R4 write err", {31'h0, e}, 32'h1);
        host(1'b0, 1'b0, 8'd5, 4'h0, 32'h0, a, e, r);
        check("R4 read err", {31'h0, e}, 32'h1);
        check("R4 read zero", r, 32'h0);
        wr_ctrl(4'h0);
        rd_arr("R4 array unchanged", 8'd5, model[5]);

        // R5 engine A emulation only
        wr_ctrl(4'h4);
        rd_ctrl("R3 emu A readback", 32'h4);
        host(1'b0, 1'b1, 8'd6, 4'hF, 32'h12345678, a, e, r);
        check("R5 host write err", {31'h0, e}, 32'h1);
        eng_a_req = 1'b1; eng_a_addr = 8'd6; eng_b_req = 1'b1; eng_b_addr = 8'd7;
        @(negedge clk);
        eng_a_req = 1'b0; eng_b_req = 1'b0;
        check("R5 eng A vld", {31'h0, eng_a_vld}, 32'h1);
        check("R5 eng A data", eng_a_data, model[6]);
        check("R5 eng B idle", {31'h0, eng_b_vld}, 32'h0);

        // R6 both engines in the same cycle
        wr_ctrl(4'hC);
        for (int i = 0; i < 20; i++) begin
            eng_a_addr = AW'($urandom()); eng_b_addr = AW'($urandom());
            eng_a_req = 1'b1; eng_b_req = 1'b1;
            ad = eng_a_addr;
            @(negedge clk);
            check("R6 eng A data", eng_a_data, model[ad]);
            check("R6 eng B data", eng_b_data, model[eng_b_addr]);
            check("R6 both vld", {30'h0, eng_b_vld, eng_a_vld}, 32'h3);
        end
        eng_a_req = 1'b0; eng_b_req = 1'b0;

        // R9 stop refused while emulation is kept or newly set
        wr_ctrl(4'hD);
        rd_ctrl("R9 stop refused", 32'hC);
        wr_ctrl(4'h0);
        wr_ctrl(4'h9);
        rd_ctrl("R9 stop refused B", 32'h8);
        wr_ctrl(4'h0);
        rd_arr("R5 array unchanged", 8'd6, model[6]);

        // R7 R8 stop mode
        wr_ctrl(4'h1);
        rd_ctrl("R7 stop set", 32'h1);
        host(1'b0, 1'b0, 8'd9, 4'h0, 32'h0, a, e, r);
        check("R7 read err", {31'h0, e}, 32'h1);
        host(1'b0, 1'b1, 8'd9, 4'hF, 32'h0BADF00D, a, e, r);
        check("R7 write err", {31'h0, e}, 32'h1);
        wr_ctrl(4'hF);
        rd_ctrl("R8 only stop bit", 32'h1);
        eng_a_req = 1'b1; eng_a_addr = 8'd9;
        @(negedge clk);
        eng_a_req = 1'b0;
        check("R8 no fetch in stop", {31'h0, eng_a_vld}, 32'h0);
        wr_ctrl(4'h6);
        rd_ctrl("R8 clear keeps others", 32'h0);
        rd_arr("R7 retained", 8'd9, model[9]);

        // R10 write in flight across a synchronous reset edge
        host_req = 1'b1; host_reg_sel = 1'b0; host_we = 1'b1;
        host_addr = 8'd20; host_wstrb = 4'hF; host_wdata = 32'hCAFEF00D;
        @(negedge clk);
        check("R10 ack before reset", {30'h0, host_ack, host_err}, 32'h2);
        host_req = 1'b0; rst_n = 1'b0;
        model[20] = 32'hCAFEF00D;
        @(negedge clk);
        host_req = 1'b1; host_addr = 8'd21; host_wdata = 32'h55555555;
        @(negedge clk);
        host_req = 1'b0;
        check("R10 no ack in reset", {31'h0, host_ack}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_arr("R10 in-flight write landed", 8'd20, model[20]);
        rd_arr("R10 blocked write", 8'd21, model[21]);
        rd_ctrl("R3 after reset", 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule